// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer with Passive Release

This block sits between up to four CPUs and a legacy cascaded interrupt controller on a slow 8-bit slave bus. A CPU fetches its interrupt vector with one read request. The block turns that request into the two back-to-back acknowledge strobes the controller needs. It keeps the slave-bus ready line low for the whole exchange. It returns the captured vector to the requesting CPU when the second strobe ends.

The first CPU to be granted becomes the owner of the interrupt. It stays the owner until it signals end-of-interrupt. Any other vector read that arrives while an owner exists is answered at once with a programmable passive-release code, and the slow bus is not touched. That code tells the CPU that nothing is pending. If no valid vector appears within a bounded number of clocks, the block gives up, answers the owner with the passive-release code, frees ownership and raises a sticky error flag.

Top module: `irq_ack_seq`

## Requirements
- R1: After reset, ack_no and bus_rdy_o are high, rsp_vld_o is zero, err_o is low and the passive-release code is 0x07.
- R2: A request granted while no owner exists drives ack_no low for exactly 4 clocks, high for 2 clocks, then low for 4 clocks. With the request seen at edge E0, ack_no is low in the cycles after E0..E3 and after E6..E9.
- R3: bus_rdy_o is low from the first strobe cycle until the vector is captured, and high at every other time.
- R4: The vector is captured at the edge that ends the last clock of the second strobe, provided vec_vld_i is high. In the next cycle rsp_vld_o carries a one-hot bit for the owner and rsp_data_o equals the vector.
- R5: A request from a CPU that is not in an acknowledge sequence, made while an owner exists, is answered in the next cycle with the passive-release code. No strobe is produced.
- R6: When several CPUs request together with no owner, the lowest index becomes owner. The others receive passive release one per cycle in ascending index order, starting the cycle after the grant.
- R7: A write on pr_wr_i loads pr_code_i as the passive-release code. Every later passive-release answer returns that value.
- R8: An end-of-interrupt pulse on eoi_i from the owner, while no sequence runs, clears ownership, so the next request starts a new sequence. The same pulse from a non-owner is ignored.
- R9: If vec_vld_i is low at the capture point, the second strobe is held until it rises. If the sequence reaches 256 clocks, it ends: the owner gets the passive-release code, err_o is set, and ownership is released.
- R10: err_o stays set until err_clr_i is pulsed.
- R11: rsp_vld_o has at most one bit set per cycle. A request that is held is answered exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 4 | Per-CPU vector read request, held until answered |
| eoi_i | input | 4 | Per-CPU end-of-interrupt pulse |
| pr_wr_i | input | 1 | Load strobe for the passive-release code |
| pr_code_i | input | 8 | New passive-release code |
| err_clr_i | input | 1 | Clears the timeout error flag |
| vec_i | input | 8 | Vector driven by the interrupt controller |
| vec_vld_i | input | 1 | Controller is driving a valid vector |
| ack_no | output | 1 | Acknowledge strobe to the controller, active low |
| bus_rdy_o | output | 1 | Slave-bus ready, low while the sequence runs |
| rsp_vld_o | output | 4 | One-hot answer strobe per CPU |
| rsp_data_o | output | 8 | Returned vector or passive-release code |
| err_o | output | 1 | Sticky timeout error |

## Verification
The assertions check the following on every cycle:
- a strobe never rises before it has been low for its full length;
- ready only rises together with an answer;
- answers are one-hot;
- the error flag is sticky and only appears as a sequence ends;
- no new grant starts while an owner is held.

The exact strobe and gap waveform, the capture cycle and the returned vector are shown only by the bench scenarios. The same holds for the order of passive-release answers across all request combinations, end-of-interrupt from owner versus non-owner, the held second strobe and the 256-clock timeout.

// File: rtl/iack_pkg.sv
package iack_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ACK1 = 2'd1,
    SEQ_GAP  = 2'd2,
    SEQ_ACK2 = 2'd3
  } seq_state_e;
endpackage

// File: rtl/iack_prio_pick.sv
module iack_prio_pick #(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // lowest index wins
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = IDX_W'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/iack_ack_fsm.sv
module iack_ack_fsm
  import iack_pkg::*;
#(
  parameter int STROBE_LEN = 4,
  parameter int GAP_LEN    = 2,
  parameter int TMO_CYCLES = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic vec_vld_i,
  output logic busy_o,
  output logic ack_no,
  output logic done_o,
  output logic tmo_o
);
  localparam int PMAX = (STROBE_LEN > GAP_LEN) ? STROBE_LEN : GAP_LEN;
  localparam int PW   = $clog2(PMAX + 1);
  localparam int TW   = $clog2(TMO_CYCLES);
  localparam int RW   = $clog2(STROBE_LEN + 2) + 1;

  seq_state_e      state_q;
  logic [PW-1:0]   ph_q;
  logic [TW-1:0]   tmo_q;

  assign busy_o = (state_q != SEQ_IDLE);
  assign ack_no = !((state_q == SEQ_ACK1) || (state_q == SEQ_ACK2));
  assign done_o = (state_q == SEQ_ACK2) && (ph_q == PW'(STROBE_LEN - 1)) && vec_vld_i;
  assign tmo_o  = busy_o && (tmo_q == TW'(TMO_CYCLES - 1)) && !done_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      ph_q    <= '0;
      tmo_q   <= '0;
    end else if (state_q == SEQ_IDLE) begin
      if (start_i) begin
        state_q <= SEQ_ACK1;
        ph_q    <= '0;
        tmo_q   <= '0;
      end
    end else if (done_o || tmo_o) begin
      state_q <= SEQ_IDLE;
      ph_q    <= '0;
      tmo_q   <= '0;
    end else begin
      tmo_q <= tmo_q + 1'b1;
      unique case (state_q)
        SEQ_ACK1: begin
          if (ph_q == PW'(STROBE_LEN - 1)) begin
            state_q <= SEQ_GAP;
            ph_q    <= '0;
          end else ph_q <= ph_q + 1'b1;
        end
        SEQ_GAP: begin
          if (ph_q == PW'(GAP_LEN - 1)) begin
            state_q <= SEQ_ACK2;
            ph_q    <= '0;
          end else ph_q <= ph_q + 1'b1;
        end
        SEQ_ACK2: begin
          // hold on the last strobe clock until the vector is valid
          if (ph_q != PW'(STROBE_LEN - 1)) ph_q <= ph_q + 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // run length of the low strobe, saturating
  logic [RW-1:0] low_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_run_q <= '0;
    else if (ack_no) low_run_q <= '0;
    else if (low_run_q != '1) low_run_q <= low_run_q + 1'b1;
  end

  AST_STROBE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_no) |-> (low_run_q >= RW'(STROBE_LEN))) else $error("strobe too short"); // R2
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import iack_pkg::*;
#(
  parameter int          N_CPU      = 4,
  parameter int          VEC_W      = 8,
  parameter int          STROBE_LEN = 4,
  parameter int          GAP_LEN    = 2,
  parameter int          TMO_CYCLES = 256,
  parameter logic [7:0]  PR_RESET   = 8'h07
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CPU-1:0] rd_req_i,
  input  logic [N_CPU-1:0] eoi_i,
  input  logic             pr_wr_i,
  input  logic [VEC_W-1:0] pr_code_i,
  input  logic             err_clr_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             vec_vld_i,
  output logic             ack_no,
  output logic             bus_rdy_o,
  output logic [N_CPU-1:0] rsp_vld_o,
  output logic [VEC_W-1:0] rsp_data_o,
  output logic             err_o
);
  localparam int IDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1;

  logic             owner_vld_q;
  logic [IDX_W-1:0] owner_idx_q;
  logic [N_CPU-1:0] served_q;
  logic [N_CPU-1:0] rsp_vld_q;
  logic [VEC_W-1:0] rsp_data_q;
  logic [VEC_W-1:0] pr_code_q;
  logic             err_q;

  logic             busy, done, tmo, start;
  logic [N_CPU-1:0] own_mask, cand, pick_gnt;
  logic [IDX_W-1:0] pick_idx;
  logic             pick_any;
  logic [N_CPU-1:0] rsp_vld_d;
  logic [VEC_W-1:0] rsp_data_d;

  always_comb begin
    own_mask = '0;
    if (owner_vld_q) own_mask[owner_idx_q] = 1'b1;
  end

  // owner in an active sequence is waiting for its vector
  assign cand  = rd_req_i & ~served_q & (busy ? ~own_mask : {N_CPU{1'b1}});
  assign start = !owner_vld_q && !busy && pick_any;

  iack_prio_pick #(.N(N_CPU), .IDX_W(IDX_W)) u_pick (
    .req_i (cand),
    .gnt_o (pick_gnt),
    .idx_o (pick_idx),
    .any_o (pick_any)
  );

  iack_ack_fsm #(
    .STROBE_LEN (STROBE_LEN),
    .GAP_LEN    (GAP_LEN),
    .TMO_CYCLES (TMO_CYCLES)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .vec_vld_i (vec_vld_i),
    .busy_o    (busy),
    .ack_no    (ack_no),
    .done_o    (done),
    .tmo_o     (tmo)
  );

  always_comb begin
    rsp_vld_d  = '0;
    rsp_data_d = rsp_data_q;
    if (done || tmo) begin
      rsp_vld_d  = own_mask;
      rsp_data_d = done ? vec_i : pr_code_q;
    end else if (owner_vld_q && !start && pick_any) begin
      rsp_vld_d  = pick_gnt;
      rsp_data_d = pr_code_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_vld_q <= 1'b0;
      owner_idx_q <= '0;
      served_q    <= '0;
      rsp_vld_q   <= '0;
      rsp_data_q  <= '0;
      pr_code_q   <= VEC_W'(PR_RESET);
      err_q       <= 1'b0;
    end else begin
      rsp_vld_q  <= rsp_vld_d;
      rsp_data_q <= rsp_data_d;
      served_q   <= (served_q & rd_req_i) | rsp_vld_d;
      if (pr_wr_i) pr_code_q <= pr_code_i;
      if (start) begin
        owner_vld_q <= 1'b1;
        owner_idx_q <= pick_idx;
      end else if (tmo) begin
        owner_vld_q <= 1'b0;
      end else if (owner_vld_q && !busy && eoi_i[owner_idx_q]) begin
        owner_vld_q <= 1'b0;
      end
      if (tmo) err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
    end
  end

  assign bus_rdy_o  = !busy;
  assign rsp_vld_o  = rsp_vld_q;
  assign rsp_data_o = rsp_data_q;
  assign err_o      = err_q;

  AST_RSP_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rsp_vld_o)) else $error("multiple answers"); // R11
  AST_RDY_WITH_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_rdy_o) |-> (rsp_vld_o != '0)) else $error("ready without answer"); // R4
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o) else $error("error flag lost"); // R10
  AST_ERR_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $rose(bus_rdy_o)) else $error("error outside sequence end"); // R9
  AST_NO_GRANT_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_rdy_o) |-> !$past(owner_vld_q)) else $error("grant while owned"); // R8
endmodule

// File: tb/irq_ack_seq_tb.sv
`timescale 1ns/1ps
module irq_ack_seq_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic [3:0] req, eoi;
  logic       pr_wr;
  logic [7:0] pr_code;
  logic       err_clr;
  logic [7:0] vec;
  logic       vec_vld;
  logic       ack_n, rdy, err;
  logic [3:0] rsp_vld;
  logic [7:0] rsp_data;

  int checks = 0, errors = 0, samp = 0, n_rsp = 0;
  int r_idx[16], r_dat[16], r_smp[16];
  int cur_pr = 8'h07;

  irq_ack_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_i(req), .eoi_i(eoi),
    .pr_wr_i(pr_wr), .pr_code_i(pr_code), .err_clr_i(err_clr),
    .vec_i(vec), .vec_vld_i(vec_vld), .ack_no(ack_n), .bus_rdy_o(rdy),
    .rsp_vld_o(rsp_vld), .rsp_data_o(rsp_data), .err_o(err)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    samp++;
    for (int i = 0; i < 4; i++) begin
      if (rsp_vld[i]) begin
        if (n_rsp < 16) begin
          r_idx[n_rsp] = i; r_dat[n_rsp] = rsp_data; r_smp[n_rsp] = samp;
        end
        n_rsp++;
        req[i] = 1'b0;
      end
    end
  endtask

  task automatic new_scn();
    samp = 0; n_rsp = 0;
  endtask

  task automatic eoi_pulse(input int i);
    eoi[i] = 1'b1; tick(); eoi = '0; tick();
  endtask

  task automatic write_pr(input int v);
    pr_wr = 1'b1; pr_code = 8'(v); tick(); pr_wr = 1'b0; cur_pr = v;
  endtask

  // full sequence with vector ready: waveform and answer
  task automatic run_seq(input int cpu, input int v);
    new_scn();
    vec = 8'(v); vec_vld = 1'b1; req[cpu] = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      tick();
      chk(ack_n == !((k >= 1 && k <= 4) || (k >= 7 && k <= 10)), "R2 strobe", ack_n, k);
      chk(rdy == !(k <= 10), "R3 ready", rdy, k);
    end
    chk(n_rsp == 1 && r_idx[0] == cpu, "R4 owner answer", r_idx[0], cpu);
    chk(r_dat[0] == v && r_smp[0] == 11, "R4 vector", r_dat[0], v);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog act=1 exp=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = '0; eoi = '0; pr_wr = 1'b0; pr_code = '0;
    err_clr = 1'b0; vec = '0; vec_vld = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk(ack_n == 1'b1, "R1 ack_no", ack_n, 1);
    chk(rdy == 1'b1, "R1 ready", rdy, 1);
    chk(rsp_vld == 4'b0, "R1 rsp", rsp_vld, 0);
    chk(err == 1'b0, "R1 err", err, 0);

    // single read by cpu0
    run_seq(0, 8'h5A);

    // R5 + R1 reset code: cpu2 while cpu0 owns
    new_scn(); req[2] = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      tick();
      chk(ack_n == 1'b1, "R5 no strobe", ack_n, 1);
    end
    chk(n_rsp == 1 && r_idx[0] == 2 && r_smp[0] == 1, "R5 immediate", r_smp[0], 1);
    chk(r_dat[0] == 8'h07, "R1 reset pr code", r_dat[0], 8'h07);

    // R8 non-owner eoi ignored
    eoi_pulse(1);
    new_scn(); req[1] = 1'b1; tick(); tick();
    chk(n_rsp == 1 && r_dat[0] == cur_pr && ack_n, "R8 non-owner eoi ignored", r_dat[0], cur_pr);
    // R8 owner eoi releases
    eoi_pulse(0);
    run_seq(3, 8'hC3);
    eoi_pulse(3);

    // R6 R7 R11 sweep over every request pattern
    for (int m = 1; m < 16; m++) begin
      int own, e_idx[4], e_smp[4], e_dat[4], ne;
      write_pr(8'h80 + m);
      own = 0;
      while (!m[own]) own++;
      ne = 0;
      for (int i = 0; i < 4; i++)
        if (m[i] && i != own) begin
          e_idx[ne] = i; e_smp[ne] = ne + 2; e_dat[ne] = 8'h80 + m; ne++;
        end
      e_idx[ne] = own; e_smp[ne] = 11; e_dat[ne] = 8'h40 + m; ne++;
      new_scn();
      vec = 8'(8'h40 + m); vec_vld = 1'b1; req = 4'(m);
      repeat (13) tick();
      chk(n_rsp == ne, "R11 answer count", n_rsp, ne);
      for (int j = 0; j < ne && j < n_rsp; j++) begin
        chk(r_idx[j] == e_idx[j], "R6 order", r_idx[j], e_idx[j]);
        chk(r_smp[j] == e_smp[j], "R6 timing", r_smp[j], e_smp[j]);
        chk(r_dat[j] == e_dat[j], "R7 data", r_dat[j], e_dat[j]);
      end
      eoi_pulse(own);
    end

    // R9 held second strobe
    new_scn(); vec_vld = 1'b0; req[1] = 1'b1;
    repeat (20) tick();
    chk(ack_n == 1'b0 && rdy == 1'b0, "R9 strobe held", ack_n, 0);
    vec = 8'h33; vec_vld = 1'b1;
    tick();
    chk(n_rsp == 1 && r_smp[0] == 21 && r_dat[0] == 8'h33, "R9 late vector", r_smp[0], 21);
    eoi_pulse(1);

    // R9 timeout
    new_scn(); vec_vld = 1'b0; req[0] = 1'b1;
    while (n_rsp == 0 && samp < 300) tick();
    chk(samp == 257, "R9 timeout cycle", samp, 257);
    chk(r_dat[0] == cur_pr && r_idx[0] == 0, "R9 timeout code", r_dat[0], cur_pr);
    chk(err == 1'b1 && ack_n == 1'b1 && rdy == 1'b1, "R9 err set", err, 1);
    repeat (5) tick();
    chk(err == 1'b1, "R10 sticky", err, 1);
    err_clr = 1'b1; tick(); err_clr = 1'b0; tick();
    chk(err == 1'b0, "R10 clear", err, 0);
    // ownership released by timeout
    run_seq(2, 8'h99);
    eoi_pulse(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule